// File: doc/BRIEF.md
# Masked Prefix Route Lookup Engine

This block is a small programmable route table for a packet forwarding path. A caller presents a 32-bit key, normally an IPv4 destination address, together with a request pulse. The engine then walks its entry table one slot per clock. Each slot holds a value, a mask and a valid flag, and a slot matches when the key and the value agree on every bit the mask selects. Of the matching slots, the one whose mask has the most set bits wins. The winner's index then selects a record in a separate associated-data table, which supplies an egress port bitmap, a next-hop MAC address and a statistics bucket number.

The same engine serves as an exact-match table when software loads every mask with all ones. Entries are loaded through a write port that carries the slot index, the match fields and the associated record in one cycle. A write that arrives while a scan is running is parked in a single holding slot. It is committed once the scan has finished, so a lookup always sees one consistent table.

Top module: `prefix_lookup_engine`

## Requirements
- R1: After reset, lk_busy, lk_done, lk_miss, lk_index, lk_ports, lk_mac and lk_bucket are all zero, and every slot is invalid, so the first lookup misses.
- R2: A valid slot matches when (key AND mask) equals (value AND mask). A zero mask matches every key.
- R3: Among matching slots, the slot whose mask has the larger number of one bits wins.
- R4: When matching slots have the same number of mask ones, the lower slot index wins.
- R5: When no valid slot matches, lk_done is raised with lk_miss=1, and lk_index, lk_ports, lk_mac and lk_bucket are all 0.
- R6: On a hit, lk_miss=0, lk_index is the winning slot, and lk_ports, lk_mac and lk_bucket carry that slot's associated record. The result outputs hold their values until the next lk_done.
- R7: A request taken while idle raises lk_busy at the next edge. lk_done is high for exactly one cycle, ENTRIES (16) clocks after the accepting edge, and lk_busy is low in that cycle. A request in the done cycle is accepted.
- R8: lk_req is ignored while lk_busy is high. It does not alter the running scan's key or its timing.
- R9: A write while idle takes effect at that clock edge. A write while busy does not affect the running scan; it is held and committed at the end of the done cycle. A second write while busy replaces the held one.
- R10: With all-ones masks, the table behaves as an exact-match table. Only a slot with an identical value hits, and duplicates resolve to the lowest index.
- R11: A slot written with valid=0 never matches, whatever its value and mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request, sampled while idle |
| lk_key | input | KEY_W | Lookup key |
| lk_busy | output | 1 | Scan in progress |
| lk_done | output | 1 | One-cycle completion pulse |
| lk_miss | output | 1 | No valid slot matched |
| lk_index | output | IDX_W | Winning slot index |
| lk_ports | output | PORT_W | Egress port bitmap of the winner |
| lk_mac | output | MAC_W | Next-hop MAC address of the winner |
| lk_bucket | output | BKT_W | Statistics bucket of the winner |
| pg_we | input | 1 | Slot write strobe |
| pg_index | input | IDX_W | Slot to write |
| pg_value | input | KEY_W | Match value |
| pg_mask | input | KEY_W | Match mask |
| pg_valid | input | 1 | Slot valid flag |
| pg_ports | input | PORT_W | Associated port bitmap |
| pg_mac | input | MAC_W | Associated next-hop MAC address |
| pg_bucket | input | BKT_W | Associated statistics bucket |

## Verification
The only place internal errors become visible is the result produced at lk_done, and that can come as late as a full scan after the cause. A wrong stored prefix length or a wrong running best-match register shows up as a wrong lk_index on the next lookup whose key hits the affected slots. A scan counter that is off by one moves lk_done one cycle early or late. A holding slot that commits at the wrong time shows up as a stale or premature result on the lookup that straddles the write. Because of this, the reference model is compared on every clock, and lookups are repeated immediately after each table change.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int unsigned DEF_KEY_W   = 32;
  localparam int unsigned DEF_ENTRIES = 16;
  localparam int unsigned DEF_PORT_W  = 4;
  localparam int unsigned DEF_MAC_W   = 48;
  localparam int unsigned DEF_BKT_W   = 4;
endpackage

// File: rtl/lpm_entry_store.sv
module lpm_entry_store #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned KEY_W   = 32,
  parameter int unsigned PORT_W  = 4,
  parameter int unsigned MAC_W   = 48,
  parameter int unsigned BKT_W   = 4,
  parameter int unsigned IDX_W   = $clog2(ENTRIES),
  parameter int unsigned LEN_W   = $clog2(KEY_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [KEY_W-1:0]  wvalue,
  input  logic [KEY_W-1:0]  wmask,
  input  logic              wvalid,
  input  logic [PORT_W-1:0] wport,
  input  logic [MAC_W-1:0]  wmac,
  input  logic [BKT_W-1:0]  wbkt,
  input  logic [IDX_W-1:0]  scan_idx,
  output logic              ent_valid,
  output logic [KEY_W-1:0]  ent_value,
  output logic [KEY_W-1:0]  ent_mask,
  output logic [LEN_W-1:0]  ent_len,
  input  logic [IDX_W-1:0]  res_idx,
  output logic [PORT_W-1:0] res_port,
  output logic [MAC_W-1:0]  res_mac,
  output logic [BKT_W-1:0]  res_bkt
);
  logic              vld_q [ENTRIES];
  logic [KEY_W-1:0]  val_q [ENTRIES];
  logic [KEY_W-1:0]  msk_q [ENTRIES];
  logic [LEN_W-1:0]  len_q [ENTRIES];
  logic [PORT_W-1:0] prt_q [ENTRIES];
  logic [MAC_W-1:0]  mac_q [ENTRIES];
  logic [BKT_W-1:0]  bkt_q [ENTRIES];
  logic [LEN_W-1:0]  wlen;

  // prefix length counted once at write time
  always_comb begin
    wlen = '0;
    for (int b = 0; b < int'(KEY_W); b++) wlen = wlen + LEN_W'(wmask[b]);
  end

  for (genvar g = 0; g < int'(ENTRIES); g++) begin : g_slot
    logic slot_en;
    assign slot_en = we && (widx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
        val_q[g] <= '0;
        msk_q[g] <= '0;
        len_q[g] <= '0;
        prt_q[g] <= '0;
        mac_q[g] <= '0;
        bkt_q[g] <= '0;
      end else if (slot_en) begin
        vld_q[g] <= wvalid;
        val_q[g] <= wvalue;
        msk_q[g] <= wmask;
        len_q[g] <= wlen;
        prt_q[g] <= wport;
        mac_q[g] <= wmac;
        bkt_q[g] <= wbkt;
      end
    end
  end

  assign ent_valid = vld_q[scan_idx];
  assign ent_value = val_q[scan_idx];
  assign ent_mask  = msk_q[scan_idx];
  assign ent_len   = len_q[scan_idx];
  assign res_port  = prt_q[res_idx];
  assign res_mac   = mac_q[res_idx];
  assign res_bkt   = bkt_q[res_idx];
endmodule

// File: rtl/lpm_match_unit.sv
module lpm_match_unit #(
  parameter int unsigned KEY_W = 32,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned LEN_W = 6
) (
  input  logic [KEY_W-1:0] key,
  input  logic [IDX_W-1:0] cur_idx,
  input  logic             ent_valid,
  input  logic [KEY_W-1:0] ent_value,
  input  logic [KEY_W-1:0] ent_mask,
  input  logic [LEN_W-1:0] ent_len,
  input  logic             best_v,
  input  logic [LEN_W-1:0] best_len,
  input  logic [IDX_W-1:0] best_idx,
  output logic             nxt_v,
  output logic [LEN_W-1:0] nxt_len,
  output logic [IDX_W-1:0] nxt_idx
);
  logic hit, take;
  assign hit  = ent_valid && (((key ^ ent_value) & ent_mask) == '0);
  // strict compare keeps the earlier (lower) index on equal length
  assign take = hit && (!best_v || (ent_len > best_len));

  always_comb begin
    nxt_v   = best_v;
    nxt_len = best_len;
    nxt_idx = best_idx;
    if (take) begin
      nxt_v   = 1'b1;
      nxt_len = ent_len;
      nxt_idx = cur_idx;
    end
  end
endmodule

// File: rtl/lpm_write_hold.sv
module lpm_write_hold #(
  parameter int unsigned WR_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            busy,
  input  logic            in_we,
  input  logic [WR_W-1:0] in_data,
  output logic            st_we,
  output logic [WR_W-1:0] st_data
);
  logic            hold_v_q, hold_v_d;
  logic [WR_W-1:0] hold_q, hold_d;
  logic            hold_en;

  always_comb begin
    st_we    = 1'b0;
    st_data  = in_data;
    hold_v_d = hold_v_q;
    hold_d   = in_data;
    hold_en  = 1'b0;
    if (busy) begin
      if (in_we) begin
        hold_v_d = 1'b1;
        hold_en  = 1'b1;
      end
    end else if (hold_v_q) begin
      st_we    = 1'b1;
      st_data  = hold_q;
      hold_v_d = in_we;
      hold_en  = in_we;
    end else begin
      st_we = in_we;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v_q <= 1'b0;
      hold_q   <= '0;
    end else begin
      hold_v_q <= hold_v_d;
      if (hold_en) hold_q <= hold_d;
    end
  end
endmodule

// File: rtl/prefix_lookup_engine.sv
module prefix_lookup_engine
  import lpm_pkg::*;
#(
  parameter int unsigned KEY_W   = DEF_KEY_W,
  parameter int unsigned ENTRIES = DEF_ENTRIES,
  parameter int unsigned PORT_W  = DEF_PORT_W,
  parameter int unsigned MAC_W   = DEF_MAC_W,
  parameter int unsigned BKT_W   = DEF_BKT_W,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [KEY_W-1:0]  lk_key,
  output logic              lk_busy,
  output logic              lk_done,
  output logic              lk_miss,
  output logic [IDX_W-1:0]  lk_index,
  output logic [PORT_W-1:0] lk_ports,
  output logic [MAC_W-1:0]  lk_mac,
  output logic [BKT_W-1:0]  lk_bucket,
  input  logic              pg_we,
  input  logic [IDX_W-1:0]  pg_index,
  input  logic [KEY_W-1:0]  pg_value,
  input  logic [KEY_W-1:0]  pg_mask,
  input  logic              pg_valid,
  input  logic [PORT_W-1:0] pg_ports,
  input  logic [MAC_W-1:0]  pg_mac,
  input  logic [BKT_W-1:0]  pg_bucket
);
  localparam int unsigned LEN_W = $clog2(KEY_W + 1);
  localparam int unsigned WR_W  = IDX_W + 2*KEY_W + 1 + PORT_W + MAC_W + BKT_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  // scan state
  logic              busy_q, busy_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [KEY_W-1:0]  key_q, key_d;
  logic              bv_q, bv_d;
  logic [LEN_W-1:0]  bl_q, bl_d;
  logic [IDX_W-1:0]  bi_q, bi_d;
  // result registers
  logic              done_d, miss_d, res_en;
  logic [IDX_W-1:0]  index_d;
  logic [PORT_W-1:0] ports_d;
  logic [MAC_W-1:0]  mac_d;
  logic [BKT_W-1:0]  bkt_d;

  // table write path
  logic [WR_W-1:0]   pg_bundle, st_bundle;
  logic              st_we, s_valid;
  logic [IDX_W-1:0]  s_idx;
  logic [KEY_W-1:0]  s_value, s_mask;
  logic [PORT_W-1:0] s_port;
  logic [MAC_W-1:0]  s_mac;
  logic [BKT_W-1:0]  s_bkt;

  logic              e_valid, n_v;
  logic [KEY_W-1:0]  e_value, e_mask;
  logic [LEN_W-1:0]  e_len, n_len;
  logic [IDX_W-1:0]  n_idx;
  logic [PORT_W-1:0] a_port;
  logic [MAC_W-1:0]  a_mac;
  logic [BKT_W-1:0]  a_bkt;
  logic              last;

  assign pg_bundle = {pg_index, pg_value, pg_mask, pg_valid, pg_ports, pg_mac, pg_bucket};
  assign {s_idx, s_value, s_mask, s_valid, s_port, s_mac, s_bkt} = st_bundle;

  lpm_write_hold #(.WR_W(WR_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .busy(busy_q),
    .in_we(pg_we), .in_data(pg_bundle),
    .st_we(st_we), .st_data(st_bundle)
  );

  lpm_entry_store #(
    .ENTRIES(ENTRIES), .KEY_W(KEY_W), .PORT_W(PORT_W), .MAC_W(MAC_W),
    .BKT_W(BKT_W), .IDX_W(IDX_W), .LEN_W(LEN_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .we(st_we), .widx(s_idx),
    .wvalue(s_value), .wmask(s_mask), .wvalid(s_valid),
    .wport(s_port), .wmac(s_mac), .wbkt(s_bkt),
    .scan_idx(idx_q), .ent_valid(e_valid), .ent_value(e_value),
    .ent_mask(e_mask), .ent_len(e_len),
    .res_idx(n_idx), .res_port(a_port), .res_mac(a_mac), .res_bkt(a_bkt)
  );

  lpm_match_unit #(.KEY_W(KEY_W), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_match (
    .key(key_q), .cur_idx(idx_q), .ent_valid(e_valid), .ent_value(e_value),
    .ent_mask(e_mask), .ent_len(e_len), .best_v(bv_q), .best_len(bl_q),
    .best_idx(bi_q), .nxt_v(n_v), .nxt_len(n_len), .nxt_idx(n_idx)
  );

  assign last = busy_q && (idx_q == LAST_IDX);

  always_comb begin
    busy_d  = busy_q;
    idx_d   = idx_q;
    key_d   = key_q;
    bv_d    = bv_q;
    bl_d    = bl_q;
    bi_d    = bi_q;
    done_d  = 1'b0;
    res_en  = 1'b0;
    miss_d  = 1'b1;
    index_d = '0;
    ports_d = '0;
    mac_d   = '0;
    bkt_d   = '0;
    if (busy_q) begin
      bv_d  = n_v;
      bl_d  = n_len;
      bi_d  = n_idx;
      idx_d = idx_q + 1'b1;
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        res_en = 1'b1;
        if (n_v) begin
          miss_d  = 1'b0;
          index_d = n_idx;
          ports_d = a_port;
          mac_d   = a_mac;
          bkt_d   = a_bkt;
        end
      end
    end else if (lk_req) begin
      busy_d = 1'b1;
      idx_d  = '0;
      key_d  = lk_key;
      bv_d   = 1'b0;
      bl_d   = '0;
      bi_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      idx_q     <= '0;
      key_q     <= '0;
      bv_q      <= 1'b0;
      bl_q      <= '0;
      bi_q      <= '0;
      lk_done   <= 1'b0;
      lk_miss   <= 1'b0;
      lk_index  <= '0;
      lk_ports  <= '0;
      lk_mac    <= '0;
      lk_bucket <= '0;
    end else begin
      busy_q  <= busy_d;
      idx_q   <= idx_d;
      key_q   <= key_d;
      bv_q    <= bv_d;
      bl_q    <= bl_d;
      bi_q    <= bi_d;
      lk_done <= done_d;
      if (res_en) begin
        lk_miss   <= miss_d;
        lk_index  <= index_d;
        lk_ports  <= ports_d;
        lk_mac    <= mac_d;
        lk_bucket <= bkt_d;
      end
    end
  end

  assign lk_busy = busy_q;
endmodule

// File: rtl/lpm_checker.sv
module lpm_checker #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned PORT_W  = 4,
  parameter int unsigned MAC_W   = 48,
  parameter int unsigned BKT_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_req,
  input logic              lk_busy,
  input logic              lk_done,
  input logic              lk_miss,
  input logic [IDX_W-1:0]  lk_index,
  input logic [PORT_W-1:0] lk_ports,
  input logic [MAC_W-1:0]  lk_mac,
  input logic [BKT_W-1:0]  lk_bucket
);
  localparam int unsigned CW = $clog2(ENTRIES + 2) + 1;
  logic [CW-1:0] since_q;

  // edges since the accepting edge, counted while busy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  since_q <= '0;
    else if (!lk_busy && lk_req) since_q <= '0;
    else if (lk_busy)            since_q <= since_q + 1'b1;
  end

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    lk_done |-> (since_q == CW'(ENTRIES)));                                  // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_done |=> !lk_done);                                                  // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_done |-> !lk_busy);                                                  // R7
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!lk_busy && lk_req) |=> lk_busy);                                      // R7
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_done && lk_miss) |-> (lk_ports == '0 && lk_index == '0 && lk_mac == '0 && lk_bucket == '0)); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_done |-> $stable({lk_miss, lk_index, lk_ports, lk_mac, lk_bucket})); // R6
endmodule

bind prefix_lookup_engine lpm_checker #(
  .ENTRIES(ENTRIES), .IDX_W(IDX_W), .PORT_W(PORT_W), .MAC_W(MAC_W), .BKT_W(BKT_W)
) u_lpm_checker (
  .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_busy(lk_busy),
  .lk_done(lk_done), .lk_miss(lk_miss), .lk_index(lk_index),
  .lk_ports(lk_ports), .lk_mac(lk_mac), .lk_bucket(lk_bucket)
);

// File: tb/prefix_lookup_engine_test.sv
module prefix_lookup_engine_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_req;
  logic [31:0] lk_key;
  logic        lk_busy, lk_done, lk_miss;
  logic [3:0]  lk_index, lk_ports, lk_bucket;
  logic [47:0] lk_mac;
  logic        pg_we, pg_valid;
  logic [3:0]  pg_index, pg_ports, pg_bucket;
  logic [31:0] pg_value, pg_mask;
  logic [47:0] pg_mac;

  prefix_lookup_engine uut (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_key(lk_key),
    .lk_busy(lk_busy), .lk_done(lk_done), .lk_miss(lk_miss),
    .lk_index(lk_index), .lk_ports(lk_ports), .lk_mac(lk_mac),
    .lk_bucket(lk_bucket), .pg_we(pg_we), .pg_index(pg_index),
    .pg_value(pg_value), .pg_mask(pg_mask), .pg_valid(pg_valid),
    .pg_ports(pg_ports), .pg_mac(pg_mac), .pg_bucket(pg_bucket)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int wd     = 0;

  // reference model state
  bit          t_v [16];
  logic [31:0] t_val [16], t_msk [16];
  logic [3:0]  t_prt [16], t_bkt [16];
  logic [47:0] t_mac [16];
  bit          m_busy = 0;
  int          m_cnt  = 0;
  logic [31:0] m_key  = '0;
  bit          h_v = 0;
  logic [3:0]  h_idx, h_prt, h_bkt;
  logic [31:0] h_val, h_msk;
  bit          h_valid;
  logic [47:0] h_mac;
  bit          e_done = 0, e_miss = 0;
  logic [3:0]  e_idx = '0, e_prt = '0, e_bkt = '0;
  logic [47:0] e_mac = '0;

  function automatic logic [31:0] pfx(int len);
    return (len == 0) ? 32'h0 : (32'hFFFF_FFFF << (32 - len));
  endfunction

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic commit(logic [3:0] i, logic [31:0] v, logic [31:0] m, bit vl,
                        logic [3:0] p, logic [47:0] mc, logic [3:0] b);
    t_val[i] = v; t_msk[i] = m; t_v[i] = vl; t_prt[i] = p; t_mac[i] = mc; t_bkt[i] = b;
  endtask

  task automatic resolve();
    int best = -1;
    int blen = 0;
    for (int i = 0; i < 16; i++) begin
      if (t_v[i] && (((m_key ^ t_val[i]) & t_msk[i]) == 0)) begin
        int len = $countones(t_msk[i]);
        if (best < 0 || len > blen) begin best = i; blen = len; end
      end
    end
    e_miss = (best < 0);
    if (best < 0) begin e_idx = 0; e_prt = 0; e_mac = 0; e_bkt = 0; end
    else begin
      e_idx = 4'(best); e_prt = t_prt[best]; e_mac = t_mac[best]; e_bkt = t_bkt[best];
    end
  endtask

  // advance model for the coming edge, take the edge, compare
  task automatic step();
    e_done = 0;
    if (m_busy) begin
      if (pg_we) begin
        h_v = 1; h_idx = pg_index; h_val = pg_value; h_msk = pg_mask;
        h_valid = pg_valid; h_prt = pg_ports; h_mac = pg_mac; h_bkt = pg_bucket;
      end
      if (m_cnt == 15) begin resolve(); m_busy = 0; e_done = 1; end
      else m_cnt++;
    end else begin
      if (h_v) begin
        commit(h_idx, h_val, h_msk, h_valid, h_prt, h_mac, h_bkt);
        if (pg_we) begin
          h_idx = pg_index; h_val = pg_value; h_msk = pg_mask;
          h_valid = pg_valid; h_prt = pg_ports; h_mac = pg_mac; h_bkt = pg_bucket;
        end else h_v = 0;
      end else if (pg_we) begin
        commit(pg_index, pg_value, pg_mask, pg_valid, pg_ports, pg_mac, pg_bucket);
      end
      if (lk_req) begin m_busy = 1; m_cnt = 0; m_key = lk_key; end
    end
    @(posedge clk);
    #1;
    chk("R7 done/busy", {62'd0, lk_done, lk_busy}, {62'd0, e_done, m_busy});
    chk("R6 result", {lk_miss, lk_index, lk_ports, lk_bucket, lk_mac},
        {e_miss, e_idx, e_prt, e_bkt, e_mac});
  endtask

  task automatic wr(logic [3:0] i, logic [31:0] v, logic [31:0] m, bit vl);
    pg_we = 1; pg_index = i; pg_value = v; pg_mask = m; pg_valid = vl;
    pg_ports = i ^ 4'h5; pg_mac = {32'hA0B1_C2D3, 12'h0, i}; pg_bucket = ~i;
    step();
    pg_we = 0;
  endtask

  task automatic look(logic [31:0] k);
    lk_req = 1; lk_key = k;
    step();
    lk_req = 0;
    for (int n = 0; n < 40 && !e_done; n++) step();
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", wd);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; lk_req = 0; lk_key = 0; pg_we = 0; pg_index = 0; pg_value = 0;
    pg_mask = 0; pg_valid = 0; pg_ports = 0; pg_mac = 0; pg_bucket = 0;
    for (int i = 0; i < 16; i++) commit(4'(i), 0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    #1;
    // R1: reset state
    chk("R1 reset outputs", {lk_busy, lk_done, lk_miss, lk_index, lk_ports, lk_bucket, lk_mac},
        64'd0);
    look(32'h0A01_0203);
    chk("R1 empty table misses", {63'd0, lk_miss}, 64'd1);

    // route set: default, /8, two equal /16s, /24
    wr(4'd15, 32'h0, pfx(0), 1);
    wr(4'd3,  32'h0A00_0000, pfx(8), 1);
    wr(4'd7,  32'h0A01_0000, pfx(16), 1);
    wr(4'd2,  32'h0A01_0000, pfx(16), 1);
    wr(4'd5,  32'h0A01_0200, pfx(24), 1);
    look(32'h0A01_0203);
    chk("R3 longest prefix", {60'd0, lk_index}, 64'd5);
    look(32'h0A01_0909);
    chk("R4 tie lower index", {60'd0, lk_index}, 64'd2);
    look(32'h0A09_0909);
    chk("R2 masked compare /8", {60'd0, lk_index}, 64'd3);
    look(32'hC0A8_0001);
    chk("R2 zero mask default", {60'd0, lk_index}, 64'd15);
    chk("R6 assoc ports", {60'd0, lk_ports}, {60'd0, 4'd15 ^ 4'h5});

    wr(4'd2, 32'h0A01_0000, pfx(16), 0);
    look(32'h0A01_0909);
    chk("R11 invalid skipped", {60'd0, lk_index}, 64'd7);
    wr(4'd15, 32'h0, pfx(0), 0);
    look(32'hC0A8_0001);
    chk("R5 miss flag", {63'd0, lk_miss}, 64'd1);
    chk("R5 miss ports zero", {60'd0, lk_ports}, 64'd0);

    // R9: write during scan is deferred
    lk_req = 1; lk_key = 32'h0A01_0203; step(); lk_req = 0;
    repeat (4) step();
    pg_we = 1; pg_index = 5; pg_value = 32'h0A01_0200; pg_mask = pfx(24); pg_valid = 0;
    step(); pg_we = 0;
    for (int n = 0; n < 40 && !e_done; n++) step();
    chk("R9 scan sees old table", {60'd0, lk_index}, 64'd5);
    step();
    look(32'h0A01_0203);
    chk("R9 held write committed", {60'd0, lk_index}, 64'd7);

    // R8: request during scan ignored
    lk_req = 1; lk_key = 32'h0A09_0909; step();
    lk_key = 32'h0A01_0203; repeat (3) step(); lk_req = 0;
    for (int n = 0; n < 40 && !e_done; n++) step();
    chk("R8 busy request ignored", {60'd0, lk_index}, 64'd3);

    // R7: request held across done is accepted back to back
    lk_req = 1; lk_key = 32'h0A09_0909;
    for (int n = 0; n < 17; n++) step();
    chk("R7 done after 16", {63'd0, lk_done}, 64'd1);
    lk_key = 32'h0A01_0909; step(); lk_req = 0;
    chk("R7 re-accept in done cycle", {63'd0, lk_busy}, 64'd1);
    for (int n = 0; n < 40 && !e_done; n++) step();
    chk("R7 second result", {60'd0, lk_index}, 64'd7);

    // R10: exact match table
    for (int i = 0; i < 16; i++) wr(4'(i), 32'hC0A8_0100 + 32'(i), 32'hFFFF_FFFF, 1);
    wr(4'd12, 32'hC0A8_0104, 32'hFFFF_FFFF, 1);
    look(32'hC0A8_010B);
    chk("R10 exact hit", {60'd0, lk_index}, 64'd11);
    look(32'hC0A8_0104);
    chk("R10 duplicate lowest", {60'd0, lk_index}, 64'd4);
    look(32'hC0A8_0110);
    chk("R10 exact miss", {63'd0, lk_miss}, 64'd1);
    repeat (3) step();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule